// File: doc/BRIEF.md
# Display Command Decoder with Backlight Level

This block sits behind a serial link, such as an SPI slave, that delivers whole 8-bit command bytes to a panel timing controller. Each accepted byte splits into a 3-bit register address in its upper bits and a 5-bit value in its lower bits. Two addresses have an effect. One selects the panel resolution mode. The other sets the lower five bits of a 6-bit backlight level. Every other address is accepted and has no effect.

The top bit of the backlight level does not come from the serial link. It follows an active-low general-purpose input: when that input is low the bit is set, and when it is high the bit is cleared. A separate power input gates the light. The block outputs the raw 6-bit level and an effective brightness, which is the level while power is on and zero while power is off.

The block also raises a one-clock update strobe whenever the visible backlight state may have changed. A power transition always raises it. A level command or a change of the top-bit input raises it only while power is on.

Top module: `lcdbl_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, intensity, brightness, quarterRes and updatePulse are all 0.
- R2: An accepted byte is decoded as address = cmdByte[7:5] and value = cmdByte[4:0]. Address 2 replaces intensity[4:0] with the value, visible after the next rising clock edge.
- R3: Address 0 sets quarterRes to 1 when the value is nonzero and to 0 when the value is zero. The new mode is visible after the next rising clock edge.
- R4: intensity[5] follows the inverse of dimN as sampled at each rising clock edge: dimN high gives 0 and dimN low gives 1.
- R5: brightness equals intensity while the sampled power is high, and is 0 while it is low.
- R6: Every change of bkPower, rising or falling, produces updatePulse in the following cycle.
- R7: A change of dimN produces updatePulse only when bkPower is high in the cycle the change is sampled. With power low, the change is not signalled.
- R8: An accepted address-2 byte produces updatePulse only when bkPower is high in the same cycle. This holds even if the value is unchanged.
- R9: Bytes with address 1 or 3 to 7 leave intensity and quarterRes unchanged and raise no updatePulse. An address-0 byte raises no updatePulse.
- R10: updatePulse is high for exactly one cycle per triggering cycle. It is low in any cycle that follows one without a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | A command byte is presented this cycle |
| cmdByte | input | 8 | Command byte: address in [7:5], value in [4:0] |
| dimN | input | 1 | Active-low source of intensity bit 5 |
| bkPower | input | 1 | Backlight power enable |
| intensity | output | 6 | Current backlight level, 0 to 63 |
| brightness | output | 6 | Level while powered, 0 otherwise |
| quarterRes | output | 1 | 1 = quarter-resolution mode, 0 = full resolution |
| updatePulse | output | 1 | One-cycle backlight update event |

## Verification
A corrupted level register shows up on intensity one cycle after the bad write. It also shows up on brightness whenever power is high, so the random mix of level commands and top-bit toggles exposes it at once. A stale copy of the previous power or top-bit sample causes a different fault. It either drops or invents an updatePulse in the cycle after the input moves, and the bench compares the strobe on every cycle. A wrong resolution flag persists on quarterRes until the next address-0 byte, so the bench follows each mode write with idle cycles and with bytes to the ignored addresses.

// File: rtl/lcdbl_pkg.sv
package lcdbl_pkg;
  parameter int CMD_W  = 8;
  parameter int ADDR_W = 3;
  parameter int VAL_W  = 5;
  parameter int INT_W  = VAL_W + 1;

  localparam logic [ADDR_W-1:0] ADDR_RES  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DUTY = 3'd2;

  typedef struct packed {
    logic             loadDuty;
    logic             loadRes;
    logic             resQuarter;
    logic [VAL_W-1:0] dutyVal;
    logic             newBit5;
    logic             newPower;
    logic             raiseUpdate;
  } ctl_strobes_t;
endpackage

// File: rtl/lcdbl_ctrl.sv
module lcdbl_ctrl
  import lcdbl_pkg::*;
(
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdByte,
  input  logic             dimN,
  input  logic             bkPower,
  input  logic             curBit5,
  input  logic             curPower,
  output ctl_strobes_t     ctl
);
  logic [ADDR_W-1:0] cmdAddr;
  logic [VAL_W-1:0]  cmdVal;
  logic              isDuty;
  logic              isRes;
  logic              nextBit5;
  logic              bit5Moves;
  logic              powerMoves;

  assign cmdAddr = cmdByte[CMD_W-1 -: ADDR_W];
  assign cmdVal  = cmdByte[VAL_W-1:0];

  always_comb begin
    isDuty     = cmdValid && (cmdAddr == ADDR_DUTY);
    isRes      = cmdValid && (cmdAddr == ADDR_RES);
    nextBit5   = ~dimN;
    bit5Moves  = nextBit5 != curBit5;
    powerMoves = bkPower != curPower;

    ctl             = '0;
    ctl.loadDuty    = isDuty;
    ctl.loadRes     = isRes;
    ctl.resQuarter  = |cmdVal;
    ctl.dutyVal     = cmdVal;
    ctl.newBit5     = nextBit5;
    ctl.newPower    = bkPower;
    ctl.raiseUpdate = powerMoves || (bkPower && (bit5Moves || isDuty));
  end
endmodule

// File: rtl/lcdbl_datapath.sv
module lcdbl_datapath
  import lcdbl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctl_strobes_t     ctl,
  output logic [INT_W-1:0] intensity,
  output logic [INT_W-1:0] brightness,
  output logic             quarterRes,
  output logic             updatePulse,
  output logic             curBit5,
  output logic             curPower
);
  logic [VAL_W-1:0] dutyReg;
  logic             bit5Reg;
  logic             pwrReg;
  logic             resReg;
  logic             pulseReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyReg  <= '0;
      bit5Reg  <= 1'b0;
      pwrReg   <= 1'b0;
      resReg   <= 1'b0;
      pulseReg <= 1'b0;
    end else begin
      if (ctl.loadDuty) dutyReg <= ctl.dutyVal;
      if (ctl.loadRes)  resReg  <= ctl.resQuarter;
      bit5Reg  <= ctl.newBit5;
      pwrReg   <= ctl.newPower;
      pulseReg <= ctl.raiseUpdate;
    end
  end

  assign intensity   = {bit5Reg, dutyReg};
  assign brightness  = pwrReg ? intensity : '0;
  assign quarterRes  = resReg;
  assign updatePulse = pulseReg;
  assign curBit5     = bit5Reg;
  assign curPower    = pwrReg;
endmodule

// File: rtl/lcdbl_top.sv
module lcdbl_top
  import lcdbl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdByte,
  input  logic             dimN,
  input  logic             bkPower,
  output logic [INT_W-1:0] intensity,
  output logic [INT_W-1:0] brightness,
  output logic             quarterRes,
  output logic             updatePulse
);
  ctl_strobes_t ctl;
  logic         curBit5;
  logic         curPower;

  lcdbl_ctrl ctrl_i (
    .cmdValid (cmdValid),
    .cmdByte  (cmdByte),
    .dimN     (dimN),
    .bkPower  (bkPower),
    .curBit5  (curBit5),
    .curPower (curPower),
    .ctl      (ctl)
  );

  lcdbl_datapath dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .intensity   (intensity),
    .brightness  (brightness),
    .quarterRes  (quarterRes),
    .updatePulse (updatePulse),
    .curBit5     (curBit5),
    .curPower    (curPower)
  );
endmodule

// File: rtl/lcdbl_checker.sv
module lcdbl_checker
  import lcdbl_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [CMD_W-1:0] cmdByte,
  input logic             dimN,
  input logic             bkPower,
  input logic [INT_W-1:0] intensity,
  input logic [INT_W-1:0] brightness,
  input logic             quarterRes,
  input logic             updatePulse
);
  a_r2_duty_load: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cmdValid) && ($past(cmdByte[7:5]) == 3'd2))
      |-> (intensity[4:0] == $past(cmdByte[4:0])));

  a_r3_res_mode: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cmdValid) && ($past(cmdByte[7:5]) == 3'd0))
      |-> (quarterRes == ($past(cmdByte[4:0]) != 5'd0)));

  a_r4_bit5_inverse: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (intensity[5] == !$past(dimN)));

  a_r5_bright_match: assert property (@(posedge clk) disable iff (!rstN)
    (brightness != '0) |-> (brightness == intensity));

  a_r6_power_change: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && (bkPower != $past(bkPower))) |=> updatePulse);

  a_r7_r8_quiet_off: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !bkPower && !$past(bkPower)) |=> !updatePulse);
endmodule

bind lcdbl_top lcdbl_checker chk_i (.*);

// File: tb/lcdbl_top_tb_top.sv
module lcdbl_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdByte = 8'h00;
  logic       dimN = 1'b1;
  logic       bkPower = 1'b0;
  logic [5:0] intensity;
  logic [5:0] brightness;
  logic       quarterRes;
  logic       updatePulse;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [5:0] expInt   = '0;
  logic       expRes   = 1'b0;
  logic       expPwr   = 1'b0;
  logic       expPulse = 1'b0;

  always #5 clk = ~clk;

  lcdbl_top dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .dimN(dimN), .bkPower(bkPower), .intensity(intensity),
    .brightness(brightness), .quarterRes(quarterRes), .updatePulse(updatePulse)
  );

  function automatic logic [5:0] expBright(input logic p, input logic [5:0] i);
    return p ? i : 6'd0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check({tag, " intensity (R2/R4)"}, intensity, expInt);
    check({tag, " quarterRes (R3)"}, quarterRes, expRes);
    check({tag, " brightness (R5)"}, brightness, expBright(expPwr, expInt));
    check({tag, " updatePulse (R10)"}, updatePulse, expPulse);
  endtask

  task automatic step(input logic v, input logic [7:0] b, input logic d,
                      input logic p, input string tag);
    logic duty;
    @(negedge clk);
    cmdValid = v; cmdByte = b; dimN = d; bkPower = p;
    duty     = v && (b[7:5] == 3'd2);
    expPulse = (p != expPwr) || (p && ((!d) != expInt[5])) || (p && duty);
    if (duty) expInt[4:0] = b[4:0];
    if (v && (b[7:5] == 3'd0)) expRes = (b[4:0] != 5'd0);
    expInt[5] = !d;
    expPwr    = p;
    @(posedge clk);
    #2;
    checkAll(tag);
  endtask

  initial begin
    #1500000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    checkAll("R1 in reset");
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #2;
    checkAll("R1 after reset");

    step(0, 8'h00, 1, 1, "R6 power rise");
    step(0, 8'h00, 1, 1, "R10 idle after pulse");
    step(1, 8'h4A, 1, 1, "R8 duty powered R2");
    check("R2 level 10", intensity, 10);
    step(1, 8'h4A, 1, 1, "R8 same value");
    check("R8 pulse repeat", updatePulse, 1);
    step(0, 8'h00, 0, 1, "R7 dimN low powered R4");
    check("R4 level 42", intensity, 42);
    check("R7 pulse", updatePulse, 1);
    step(1, 8'h3F, 0, 1, "R9 addr1 ignored");
    check("R9 no pulse", updatePulse, 0);
    for (int a = 3; a < 8; a++)
      step(1, {a[2:0], 5'h15}, 0, 1, "R9 high addr ignored");
    step(1, 8'h01, 0, 1, "R3 quarter");
    check("R3 quarter set", quarterRes, 1);
    check("R9 addr0 no pulse", updatePulse, 0);
    step(1, 8'h1F, 0, 1, "R3 quarter max");
    step(1, 8'h00, 0, 1, "R3 full");
    check("R3 full set", quarterRes, 0);
    step(0, 8'h00, 0, 0, "R6 power fall R5");
    check("R5 off gives 0", brightness, 0);
    step(0, 8'h00, 1, 0, "R7 dimN high unpowered");
    check("R7 no pulse off", updatePulse, 0);
    step(1, 8'h5F, 1, 0, "R8 duty unpowered");
    check("R8 no pulse off", updatePulse, 0);
    check("R2 loaded while off", intensity, 31);
    step(1, 8'h40, 0, 1, "R2 zero duty with power R6");

    for (int k = 0; k < 2000; k++) begin
      logic       v;
      logic [7:0] b;
      logic       d;
      logic       p;
      v = ($urandom % 3) != 0;
      b = 8'($urandom);
      if (($urandom % 2) == 0) b[7:5] = 3'd2;
      d = (($urandom % 5) == 0) ? !dimN : dimN;
      p = (($urandom % 7) == 0) ? !bkPower : bkPower;
      step(v, b, d, p, "random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule